// File: doc/BRIEF.md
# Segmented LRU Instruction Cache

This block is a 512-byte read-only instruction store placed between an instruction fetch unit and a 32-bit memory port. The fetch side presents a bit-granular 32-bit address and holds `fetch_req` high until `fetch_rdy` returns the 32-bit long word that contains that address. A hit answers in the same cycle. On a miss the fetch side stalls while the cache loads exactly one subsegment of four long words from memory. It uses a request/acknowledge handshake for each of the four beats.

Storage is four segments of 128 bytes. Each segment carries one 22-bit region tag taken from address bits [31:10]. Each segment is split into eight subsegments of four long words, and each subsegment has its own present flag. A segment can therefore be only partly loaded. A tag match alone is not a hit: the subsegment's present flag must also be set. When no segment holds the region, the least-recently-used segment is reclaimed. A four-entry stack of two-bit segment numbers records the LRU order. A synchronous flush empties the cache and restores the stack order.

Top module: `seg_icache`

## Requirements
- R1: When the addressed subsegment is present, `fetch_rdy` is high in the same cycle as `fetch_req`. `fetch_data` is the long word chosen by address bits [6:5] within subsegment [9:7] of region [31:10]. Bits [4:0] have no effect on the result.
- R2: On a miss, `mem_req` rises in the next cycle. The four beats use `mem_addr` = {addr[31:7], beat, 5'b0}, with beat running 0, 1, 2, 3 in that order. Each beat's address is held until `mem_ack` is sampled high.
- R3: `fetch_rdy` stays low while a fill is in progress. In the cycle after the fourth acknowledged beat, the requested word is returned without another memory access.
- R4: A miss whose region tag matches a segment but whose subsegment is absent fills that subsegment in the same segment. Every other subsegment already present in that segment stays present.
- R5: A region miss loads the new tag into the LRU segment and clears that segment's eight present flags before the fill. A segment with no present flag never counts as a tag match, and no region is held in two segments.
- R6: Every hit and every completed fill moves the segment it used to the top of the LRU stack. The entries that were above it shift down by one place.
- R7: `flush` clears every present flag and sets the LRU stack to 0, 1, 2, 3 from top to bottom. Every later fetch misses until its subsegment is filled again.
- R8: A flush during a fill ends the fill. `mem_req` is low in the next cycle, and the partly loaded subsegment is not marked present.
- R9: Flush takes priority when it coincides with the final acknowledged beat or with a hit. No present flag is set, and `fetch_rdy` is low in the flush cycle.
- R10: After reset, `mem_req` is low and no fetch hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous invalidate of all contents |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_addr | input | 32 | Bit address of the wanted instruction |
| fetch_rdy | output | 1 | Requested long word is on `fetch_data` |
| fetch_data | output | 32 | Long word containing the fetch address |
| mem_req | output | 1 | Memory read request for one beat |
| mem_addr | output | 32 | Bit address of the long word being read |
| mem_ack | input | 1 | Memory has `mem_data` valid for this beat |
| mem_data | input | 32 | Read data from memory |

## Verification
Flush can arrive in the same cycle as two other events: the last acknowledged beat of a fill, or a request that would otherwise hit. The bench lets the responder acknowledge until three beats are counted. It then raises flush on the edge that carries the fourth acknowledge. It checks that `mem_req` falls and that a repeat fetch of the same address costs four new beats. For the hit case it drives flush and the request of a resident word together. It checks that `fetch_rdy` stays low, and that the word must be fetched from memory again afterwards.

// File: rtl/icache_pkg.sv
package icache_pkg;
    parameter int unsigned ADDR_W   = 32;
    parameter int unsigned DATA_W   = 32;
    parameter int unsigned N_SEG    = 4;
    parameter int unsigned N_SUB    = 8;
    parameter int unsigned N_WORD   = 4;
    parameter int unsigned BIT_LSBS = 5;

    localparam int unsigned SEG_W    = $clog2(N_SEG);
    localparam int unsigned SUB_W    = $clog2(N_SUB);
    localparam int unsigned WRD_W    = $clog2(N_WORD);
    localparam int unsigned WORD_LSB = BIT_LSBS;
    localparam int unsigned SUB_LSB  = WORD_LSB + WRD_W;
    localparam int unsigned TAG_LSB  = SUB_LSB + SUB_W;
    localparam int unsigned TAG_W    = ADDR_W - TAG_LSB;
    localparam int unsigned LINES    = N_SEG * N_SUB * N_WORD;
    localparam int unsigned IDX_W    = SEG_W + SUB_W + WRD_W;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [SUB_W-1:0] sub_t;
    typedef logic [WRD_W-1:0] wrd_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic {PH_IDLE, PH_FILL} fill_phase_e;
endpackage

// File: rtl/icache_lru.sv
module icache_lru
    import icache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic touch,
    input  seg_t touch_seg,
    output seg_t victim
);
    typedef struct packed {
        seg_t [N_SEG-1:0] stack;   // [0] = most recent, [N_SEG-1] = least recent
    } lru_state_t;

    lru_state_t st_d, st_q;
    seg_t       pos;

    always_comb begin
        st_d = st_q;
        pos  = '0;
        for (int i = 0; i < N_SEG; i++) begin
            if (st_q.stack[i] == touch_seg) pos = seg_t'(i);
        end
        if (flush) begin
            for (int i = 0; i < N_SEG; i++) st_d.stack[i] = seg_t'(i);
        end else if (touch) begin
            for (int i = N_SEG - 1; i > 0; i--) begin
                if (seg_t'(i) <= pos) st_d.stack[i] = st_q.stack[i-1];
            end
            st_d.stack[0] = touch_seg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SEG; i++) st_q.stack[i] <= seg_t'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign victim = st_q.stack[N_SEG-1];

    logic [N_SEG-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N_SEG; i++) seen[st_q.stack[i]] = 1'b1;
    end

    AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);                                                         // R6
    AST_LRU_TOUCH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        touch && !flush |=> st_q.stack[0] == $past(touch_seg));         // R6
    AST_LRU_FLUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> victim == seg_t'(N_SEG - 1));                         // R7
endmodule

// File: rtl/icache_dir.sv
module icache_dir
    import icache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  tag_t look_tag,
    input  sub_t look_sub,
    input  logic alloc,
    input  seg_t alloc_seg,
    input  tag_t alloc_tag,
    input  logic mark,
    input  seg_t mark_seg,
    input  sub_t mark_sub,
    output logic tag_hit,
    output seg_t hit_seg,
    output logic sub_present
);
    typedef struct packed {
        tag_t [N_SEG-1:0]             tags;
        logic [N_SEG-1:0][N_SUB-1:0]  pres;
    } dir_state_t;

    dir_state_t       dir_d, dir_q;
    logic [N_SEG-1:0] match;

    for (genvar s = 0; s < N_SEG; s++) begin : g_cmp
        assign match[s] = (dir_q.tags[s] == look_tag) && (|dir_q.pres[s]);
    end

    always_comb begin
        hit_seg = '0;
        for (int s = N_SEG - 1; s >= 0; s--) begin
            if (match[s]) hit_seg = seg_t'(s);
        end
        tag_hit     = |match;
        sub_present = tag_hit && dir_q.pres[hit_seg][look_sub];
    end

    always_comb begin
        dir_d = dir_q;
        if (alloc) begin
            dir_d.tags[alloc_seg] = alloc_tag;
            dir_d.pres[alloc_seg] = '0;
        end
        if (mark) dir_d.pres[mark_seg][mark_sub] = 1'b1;
        if (flush) dir_d.pres = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            dir_q <= dir_d;
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));                                               // R5
    AST_MARK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        mark && !flush |=> dir_q.pres[$past(mark_seg)][$past(mark_sub)]); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> dir_q.pres == '0);                                    // R7
endmodule

// File: rtl/icache_fill.sv
module icache_fill
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  seg_t              start_seg,
    input  tag_t              start_tag,
    input  sub_t              start_sub,
    input  logic              mem_ack,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output seg_t              wr_seg,
    output sub_t              wr_sub,
    output wrd_t              wr_word,
    output logic              done
);
    typedef struct packed {
        fill_phase_e phase;
        seg_t        seg;
        tag_t        tag;
        sub_t        sub;
        wrd_t        beat;
    } fill_state_t;

    localparam wrd_t LAST_BEAT = wrd_t'(N_WORD - 1);

    fill_state_t fs_d, fs_q;

    assign busy     = (fs_q.phase == PH_FILL);
    assign mem_req  = busy;
    assign mem_addr = {fs_q.tag, fs_q.sub, fs_q.beat, {BIT_LSBS{1'b0}}};
    assign wr_en    = busy && mem_ack && !flush;
    assign done     = wr_en && (fs_q.beat == LAST_BEAT);
    assign wr_seg   = fs_q.seg;
    assign wr_sub   = fs_q.sub;
    assign wr_word  = fs_q.beat;

    always_comb begin
        fs_d = fs_q;
        if (flush) begin
            fs_d.phase = PH_IDLE;
        end else if (!busy && start) begin
            fs_d.phase = PH_FILL;
            fs_d.seg   = start_seg;
            fs_d.tag   = start_tag;
            fs_d.sub   = start_sub;
            fs_d.beat  = '0;
        end else if (wr_en) begin
            if (fs_q.beat == LAST_BEAT) fs_d.phase = PH_IDLE;
            else                        fs_d.beat  = fs_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            fs_q <= fs_d;
        end
    end

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !flush |=> mem_req && $stable(mem_addr));  // R2
    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !done |=> mem_addr[SUB_LSB-1:WORD_LSB] ==
                           $past(mem_addr[SUB_LSB-1:WORD_LSB]) + 1'b1);    // R2
    AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !mem_req);                                              // R8
endmodule

// File: rtl/seg_icache.sv
module seg_icache
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_rdy,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data
);
    tag_t look_tag;
    sub_t look_sub;
    wrd_t look_word;
    assign look_tag  = fetch_addr[ADDR_W-1:TAG_LSB];
    assign look_sub  = fetch_addr[TAG_LSB-1:SUB_LSB];
    assign look_word = fetch_addr[SUB_LSB-1:WORD_LSB];

    logic tag_hit, sub_present, busy, wr_en, done, miss, touch;
    seg_t hit_seg, victim, fill_seg, wr_seg, touch_seg;
    sub_t wr_sub;
    wrd_t wr_word;

    // A lookup is only meaningful while idle and not flushing.
    assign fetch_rdy = fetch_req && !busy && !flush && sub_present;
    assign miss      = fetch_req && !busy && !flush && !sub_present;
    assign fill_seg  = tag_hit ? hit_seg : victim;
    assign touch     = fetch_rdy || done;
    assign touch_seg = done ? wr_seg : hit_seg;

    icache_dir u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .look_tag   (look_tag),
        .look_sub   (look_sub),
        .alloc      (miss && !tag_hit),
        .alloc_seg  (victim),
        .alloc_tag  (look_tag),
        .mark       (done),
        .mark_seg   (wr_seg),
        .mark_sub   (wr_sub),
        .tag_hit    (tag_hit),
        .hit_seg    (hit_seg),
        .sub_present(sub_present)
    );

    icache_lru u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .touch    (touch),
        .touch_seg(touch_seg),
        .victim   (victim)
    );

    icache_fill u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .start    (miss),
        .start_seg(fill_seg),
        .start_tag(look_tag),
        .start_sub(look_sub),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .wr_en    (wr_en),
        .wr_seg   (wr_seg),
        .wr_sub   (wr_sub),
        .wr_word  (wr_word),
        .done     (done)
    );

    // Data store: contents only become visible once a present flag covers them.
    logic [DATA_W-1:0] store_q [LINES];
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    assign rd_idx = {hit_seg, look_sub, look_word};
    assign wr_idx = {wr_seg, wr_sub, wr_word};

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_idx] <= mem_data;
    end

    assign fetch_data = store_q[rd_idx];

    AST_NO_HIT_WHILE_FILLING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_rdy);                                          // R3
    AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_rdy && !mem_req && !flush |=> mem_req);       // R2
    AST_FLUSH_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !fetch_rdy);                                            // R9
endmodule

// File: tb/seg_icache_test.sv
module seg_icache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;

    int compared = 0;
    int mismatched = 0;
    int acks = 0;
    bit ack_en = 1'b1;
    logic [31:0] beat_log [8];

    always #5 clk = ~clk;

    seg_icache uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        logic [31:0] w = {a[31:5], 5'b0};
        return {w[15:0], w[31:16]} ^ 32'hC3A5_0F96;
    endfunction

    function automatic logic [31:0] mk(input logic [21:0] tag, input logic [2:0] sub,
                                       input logic [1:0] wd, input logic [4:0] bt);
        return {tag, sub, wd, bt};
    endfunction

    // Memory responder
    always @(negedge clk) begin
        mem_ack  = ack_en && mem_req;
        mem_data = word_of(mem_addr);
    end
    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            beat_log[acks % 8] = mem_addr;
            acks = acks + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit exp_miss, input string req);
        int a0;
        bit got;
        @(negedge clk);
        fetch_addr = a;
        fetch_req  = 1'b1;
        a0  = acks;
        got = 1'b0;
        for (int k = 0; k < 40 && !got; k++) begin
            #1;
            if (fetch_rdy) got = 1'b1;
            else @(negedge clk);
        end
        chk(got, req, "fetch_rdy", 32'(got), 32'd1);
        chk(fetch_data === word_of(a), req, "fetch_data", fetch_data, word_of(a));
        chk((acks - a0) == (exp_miss ? 4 : 0), req, "beats used",
            32'(acks - a0), exp_miss ? 32'd4 : 32'd0);
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_req == 1'b0, "R10", "mem_req after reset", 32'(mem_req), 32'd0);
        fetch_addr = 32'h0;
        fetch_req  = 1'b1;
        #1;
        chk(fetch_rdy == 1'b0, "R10", "hit after reset", 32'(fetch_rdy), 32'd0);
        @(negedge clk);
        fetch_req = 1'b0;
        ack_en = 1'b1;
        while (mem_req) @(negedge clk);
    endtask

    task automatic t_fill_order();
        logic [31:0] a = mk(22'h12345, 3'd5, 2'd2, 5'd17);
        int base;
        ack_en = 1'b0;
        @(negedge clk);
        fetch_addr = a;
        fetch_req  = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b1, "R2", "mem_req one cycle after miss", 32'(mem_req), 32'd1);
        chk(mem_addr == {a[31:7], 7'b0}, "R2", "beat0 address", mem_addr, {a[31:7], 7'b0});
        chk(fetch_rdy == 1'b0, "R3", "stall during fill", 32'(fetch_rdy), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk(mem_addr == {a[31:7], 7'b0}, "R2", "beat0 held without ack", mem_addr, {a[31:7], 7'b0});
        base = acks;
        ack_en = 1'b1;
        while (acks != base + 4) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] e = {a[31:7], 2'(i), 5'b0};
            chk(beat_log[(base + i) % 8] == e, "R2", "beat address", beat_log[(base + i) % 8], e);
        end
        #1;
        chk(fetch_rdy == 1'b1, "R3", "ready after last beat", 32'(fetch_rdy), 32'd1);
        chk(fetch_data == word_of(a), "R3", "filled word", fetch_data, word_of(a));
        @(negedge clk);
        fetch_req = 1'b0;
        do_fetch(mk(22'h12345, 3'd5, 2'd0, 5'd0), 1'b0, "R1");
        do_fetch(mk(22'h12345, 3'd5, 2'd3, 5'd31), 1'b0, "R1");
        do_fetch(mk(22'h12345, 3'd5, 2'd2, 5'd3), 1'b0, "R1");
    endtask

    task automatic t_partial();
        do_fetch(mk(22'h12345, 3'd1, 2'd1, 5'd8), 1'b1, "R4");
        do_fetch(mk(22'h12345, 3'd5, 2'd1, 5'd0), 1'b0, "R4");
        do_fetch(mk(22'h12345, 3'd1, 2'd3, 5'd0), 1'b0, "R4");
    endtask

    task automatic t_lru();
        do_flush();
        for (int t = 0; t < 4; t++) do_fetch(mk(22'(16'hA00 + t), 3'd0, 2'd0, 5'd0), 1'b1, "R5");
        do_fetch(mk(22'hA00, 3'd0, 2'd1, 5'd0), 1'b0, "R6");   // region 0 becomes most recent
        do_fetch(mk(22'hA04, 3'd2, 2'd0, 5'd0), 1'b1, "R5");   // evicts region 1
        do_fetch(mk(22'hA00, 3'd0, 2'd0, 5'd0), 1'b0, "R6");
        do_fetch(mk(22'hA02, 3'd0, 2'd0, 5'd0), 1'b0, "R6");
        do_fetch(mk(22'hA03, 3'd0, 2'd0, 5'd0), 1'b0, "R6");
        do_fetch(mk(22'hA01, 3'd0, 2'd0, 5'd0), 1'b1, "R5");   // evicts region 4
        do_fetch(mk(22'hA04, 3'd2, 2'd0, 5'd0), 1'b1, "R6");
    endtask

    task automatic t_flush();
        do_fetch(mk(22'h0BEEF, 3'd3, 2'd0, 5'd0), 1'b1, "R7");
        do_fetch(mk(22'h0BEEF, 3'd3, 2'd0, 5'd0), 1'b0, "R7");
        do_flush();
        do_fetch(mk(22'h0BEEF, 3'd3, 2'd0, 5'd0), 1'b1, "R7");
    endtask

    task automatic flush_at_beat(input int nbeats, input logic [31:0] a, input string req);
        int base;
        @(negedge clk);
        fetch_addr = a;
        fetch_req  = 1'b1;
        base = acks;
        while (acks != base + nbeats) @(negedge clk);
        flush = 1'b1;
        fetch_req = 1'b0;
        @(negedge clk);
        flush = 1'b0;
        chk(mem_req == 1'b0, req, "mem_req after flush", 32'(mem_req), 32'd0);
        do_fetch(a, 1'b1, req);
    endtask

    task automatic t_hit_flush();
        logic [31:0] a = mk(22'h2AAAA, 3'd7, 2'd3, 5'd0);
        do_fetch(a, 1'b1, "R9");
        @(negedge clk);
        fetch_addr = a;
        fetch_req  = 1'b1;
        flush      = 1'b1;
        #1;
        chk(fetch_rdy == 1'b0, "R9", "hit blocked by flush", 32'(fetch_rdy), 32'd0);
        @(negedge clk);
        flush     = 1'b0;
        fetch_req = 1'b0;
        do_fetch(a, 1'b1, "R9");
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_order();
        t_partial();
        t_lru();
        t_flush();
        flush_at_beat(1, mk(22'h03C3C, 3'd4, 2'd1, 5'd0), "R8");
        flush_at_beat(3, mk(22'h03C3D, 3'd6, 2'd2, 5'd0), "R9");
        t_hit_flush();
        report();
    end
endmodule